// File: doc/BRIEF.md
# Port-Size Transfer Splitter

This block sits between a processor's request path and an external device bus. It accepts one aligned transfer of 1, 2, 4 or 16 bytes, together with the width of the port on the selected device (8, 16 or 32 bits). It then issues the transfer as a series of port-width beats. Each beat carries a registered address, a two-bit size code, a one-cycle address-latch strobe and active-low byte-lane strobes.

The surrounding bus logic acknowledges each beat on `beat_done`, in the same cycle as the strobe or after any number of wait cycles. The next beat opens on the following cycle. After the final acknowledge the block returns to idle and raises `done` for one cycle.

The size code follows one of two rules, chosen per request by the burst flag:
- With bursting on, every beat reports the size of the whole transfer.
- With bursting off, only the first beat reports the whole size, and each later beat reports the port size.

Top module: `xfer_splitter`

## Requirements
- R1: Size codes are 2'b00 for 4 bytes, 2'b01 for 1 byte, 2'b10 for 2 bytes and 2'b11 for 16 bytes. The first beat of every transfer shows the code of the requested size.
- R2: With `req_burst` high, every beat of the transfer shows the requested size code.
- R3: With `req_burst` low, every beat after the first shows the port code: 2'b01 for an 8-bit port (`port_width`=0), 2'b10 for a 16-bit port (`port_width`=1), and 2'b00 for a 32-bit port (`port_width`=2 or 3).
- R4: A transfer has (transfer bytes / port bytes) beats, and at least one beat.
- R5: The first beat's address is `req_addr`. Each later beat's address is the previous one plus the port width in bytes. `beat_write` equals the request's write flag on every beat.
- R6: `ale` is high for exactly the first cycle of each beat. That cycle is the one after acceptance, or the one after the previous beat's `beat_done`.
- R7: On an 8-bit port, `be_n` is 4'b1110 on every beat. Bit k of `be_n` is byte lane k, which is address offset k within a 32-bit word.
- R8: On a 16-bit port, a 1-byte transfer drives lane `addr[0]` low. Any larger transfer drives lanes 0 and 1 low (`be_n`=4'b1100).
- R9: On a 32-bit port:
  - a 1-byte transfer drives lane `addr[1:0]` low;
  - a 2-byte transfer drives lanes 2,3 low (4'b0011) when `addr[1]`=1, and lanes 0,1 low (4'b1100) otherwise;
  - 4- and 16-byte transfers drive all lanes low.
- R10: While no beat is active, `be_n` is 4'b1111.
- R11: A `req_valid` that arrives while a transfer is in progress is ignored. The current beat's address is unchanged, and no further transfer starts after `done`.
- R12: `done` is high for exactly one cycle, the cycle after the final `beat_done`, and `beat_active` is low in that cycle.
- R13: After reset, `beat_active`, `ale` and `done` are low and `be_n` is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request, taken while idle |
| req_addr | input | AW | Aligned start address |
| req_size | input | 2 | Transfer size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst mode for the size-code rule |
| port_width | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| beat_done | input | 1 | Completion of the current beat |
| beat_active | output | 1 | A beat is in progress |
| beat_addr | output | AW | Address of the current beat |
| beat_size | output | 2 | Size code of the current beat |
| beat_write | output | 1 | Direction of the current beat |
| ale | output | 1 | Address-latch strobe, first cycle of each beat |
| be_n | output | 4 | Active-low byte-lane strobes |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The hardest situation to reach from the ports is a beat held open by wait cycles while a new request arrives. The design must leave the held beat untouched and must not start a hidden second transfer once the first completes. The stimulus stalls `beat_done` for several cycles and pulses `req_valid` with an inverted address inside that window. It then checks the address during the stall, the beat count, and that the block stays idle after `done`. Both size-code rules are driven on multi-beat transfers for every port width. This separates the first beat from later beats.

// File: rtl/xs_pkg.sv
package xs_pkg;

    localparam int LANES     = 4;
    localparam int MAX_BEATS = 16;
    localparam int CNT_W     = $clog2(MAX_BEATS + 1);

    typedef enum logic [1:0] {
        SZ_QUAD = 2'b00,
        SZ_ONE  = 2'b01,
        SZ_PAIR = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef struct packed {
        xfer_size_e size;
        logic       write;
        logic       burst;
        logic [1:0] pw;
    } req_ctx_t;

    function automatic logic [CNT_W-1:0] size_bytes(input xfer_size_e s);
        case (s)
            SZ_ONE:  return CNT_W'(1);
            SZ_PAIR: return CNT_W'(2);
            SZ_QUAD: return CNT_W'(4);
            default: return CNT_W'(16);
        endcase
    endfunction

    function automatic logic [1:0] port_shift(input logic [1:0] pw);
        case (pw)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [2:0] port_bytes(input logic [1:0] pw);
        return 3'(3'd1 << port_shift(pw));
    endfunction

    function automatic xfer_size_e port_code(input logic [1:0] pw);
        case (pw)
            2'd0:    return SZ_ONE;
            2'd1:    return SZ_PAIR;
            default: return SZ_QUAD;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] beat_total(input xfer_size_e s, input logic [1:0] pw);
        logic [CNT_W-1:0] n;
        n = size_bytes(s) >> port_shift(pw);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

endpackage

// File: rtl/xs_ctrl.sv
module xs_ctrl
    import xs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  req_ctx_t req_ctx,
    input  logic     beat_done,
    output logic     accept,
    output logic     advance,
    output logic     active,
    output logic     ale,
    output logic     first,
    output logic     done,
    output req_ctx_t ctx_q
);

    logic [CNT_W-1:0] remain_q;
    logic             finish;

    assign accept  = req_valid && !active;
    assign finish  = active && beat_done && (remain_q == '0);
    assign advance = active && beat_done && (remain_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            ale      <= 1'b0;
            first    <= 1'b0;
            done     <= 1'b0;
            remain_q <= '0;
            ctx_q    <= '{size: SZ_QUAD, write: 1'b0, burst: 1'b0, pw: 2'd0};
        end else begin
            ale  <= accept || advance;
            done <= finish;
            if (accept) begin
                active   <= 1'b1;
                first    <= 1'b1;
                ctx_q    <= req_ctx;
                remain_q <= beat_total(req_ctx.size, req_ctx.pw) - CNT_W'(1);
            end else if (finish) begin
                active <= 1'b0;
                first  <= 1'b0;
            end else if (advance) begin
                first    <= 1'b0;
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/xs_addr_gen.sv
module xs_addr_gen
    import xs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic          advance,
    input  logic [1:0]    pw,
    output logic [AW-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end else if (advance) begin
            addr_q <= addr_q + AW'(port_bytes(pw));
        end
    end

endmodule

// File: rtl/xs_lane_dec.sv
module xs_lane_dec
    import xs_pkg::*;
(
    input  logic             active,
    input  logic [1:0]       pw,
    input  xfer_size_e       size,
    input  logic [1:0]       addr_lo,
    output logic [LANES-1:0] be_n
);

    logic [LANES-1:0] mask;

    always_comb begin
        case (pw)
            2'd0: mask = 4'b0001;
            2'd1: begin
                if (size == SZ_ONE) mask = addr_lo[0] ? 4'b0010 : 4'b0001;
                else                mask = 4'b0011;
            end
            default: begin
                case (size)
                    SZ_ONE:  mask = 4'(4'b0001 << addr_lo);
                    SZ_PAIR: mask = addr_lo[1] ? 4'b1100 : 4'b0011;
                    default: mask = 4'b1111;
                endcase
            end
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_n[i] = ~(active & mask[i]);
    end

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
    import xs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic [1:0]    port_width,
    input  logic          beat_done,
    output logic          beat_active,
    output logic [AW-1:0] beat_addr,
    output logic [1:0]    beat_size,
    output logic          beat_write,
    output logic          ale,
    output logic [3:0]    be_n,
    output logic          done
);

    req_ctx_t req_ctx;
    req_ctx_t ctx_q;
    logic     accept;
    logic     advance;
    logic     first;

    assign req_ctx = '{size: xfer_size_e'(req_size), write: req_write,
                       burst: req_burst, pw: port_width};

    xs_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ctx   (req_ctx),
        .beat_done (beat_done),
        .accept    (accept),
        .advance   (advance),
        .active    (beat_active),
        .ale       (ale),
        .first     (first),
        .done      (done),
        .ctx_q     (ctx_q)
    );

    xs_addr_gen #(.AW(AW)) i_addr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_addr (req_addr),
        .advance  (advance),
        .pw       (ctx_q.pw),
        .addr_q   (beat_addr)
    );

    xs_lane_dec i_lane (
        .active  (beat_active),
        .pw      (ctx_q.pw),
        .size    (ctx_q.size),
        .addr_lo (beat_addr[1:0]),
        .be_n    (be_n)
    );

    always_comb begin
        if (first || ctx_q.burst) beat_size = ctx_q.size;
        else                      beat_size = port_code(ctx_q.pw);
    end

    assign beat_write = ctx_q.write;

endmodule

// File: rtl/xs_chk.sv
module xs_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          beat_done,
    input logic          beat_active,
    input logic [AW-1:0] beat_addr,
    input logic [1:0]    beat_size,
    input logic          ale,
    input logic [3:0]    be_n,
    input logic          done
);

    AST_ALE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ale |-> beat_active) else $error("ale outside beat"); // R6

    AST_BEAT_OPENS_WITH_ALE: assert property (@(posedge clk) disable iff (rst)
        $rose(beat_active) |-> ale) else $error("beat without ale"); // R6

    AST_BEAT_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (beat_active && !ale) |-> ($stable(beat_addr) && $stable(beat_size) && $stable(be_n)))
        else $error("beat fields moved mid-beat"); // R5

    AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
        !beat_active |-> (be_n == 4'b1111)) else $error("strobes while idle"); // R10

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
        (beat_active && !beat_done && req_valid) |=> (beat_active && $stable(beat_addr)))
        else $error("request disturbed beat"); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R12

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> (!beat_active && $past(beat_active && beat_done)))
        else $error("done without final beat"); // R12

endmodule

bind xfer_splitter xs_chk #(.AW(AW)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .beat_done   (beat_done),
    .beat_active (beat_active),
    .beat_addr   (beat_addr),
    .beat_size   (beat_size),
    .ale         (ale),
    .be_n        (be_n),
    .done        (done)
);

// File: tb/test_xfer_splitter.sv
module test_xfer_splitter;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic          req_write = 1'b0;
    logic          req_burst = 1'b0;
    logic [1:0]    port_width = 2'd0;
    logic          beat_done = 1'b0;
    logic          beat_active;
    logic [AW-1:0] beat_addr;
    logic [1:0]    beat_size;
    logic          beat_write;
    logic          ale;
    logic [3:0]    be_n;
    logic          done;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    xfer_splitter #(.AW(AW)) i_xfer_splitter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_burst(req_burst),
        .port_width(port_width), .beat_done(beat_done), .beat_active(beat_active),
        .beat_addr(beat_addr), .beat_size(beat_size), .beat_write(beat_write),
        .ale(ale), .be_n(be_n), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int bytes_of(input logic [1:0] s);
        case (s)
            2'b00: return 4;
            2'b01: return 1;
            2'b10: return 2;
            default: return 16;
        endcase
    endfunction

    function automatic int pbytes(input logic [1:0] pw);
        return (pw == 2'd0) ? 1 : (pw == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [1:0] pcode(input logic [1:0] pw);
        return (pw == 2'd0) ? 2'b01 : (pw == 2'd1) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [3:0] lanes(input logic [1:0] pw, input logic [1:0] s,
                                         input logic [1:0] a);
        if (pw == 2'd0) return 4'b1110;
        if (pw == 2'd1) begin
            if (s == 2'b01) return a[0] ? 4'b1101 : 4'b1110;
            return 4'b1100;
        end
        if (s == 2'b01) return ~(4'b0001 << a);
        if (s == 2'b10) return a[1] ? 4'b0011 : 4'b1100;
        return 4'b0000;
    endfunction

    // One transfer: drives the request, walks every beat, checks done and idle.
    task automatic run_xfer(input logic [AW-1:0] a, input logic [1:0] s, input logic wr,
                            input logic bu, input logic [1:0] pw, input int waits,
                            input bit intrude);
        int nb;
        logic [AW-1:0] ea;
        nb = bytes_of(s) / pbytes(pw);
        if (nb < 1) nb = 1;
        ea = a;
        req_addr = a; req_size = s; req_write = wr; req_burst = bu; port_width = pw;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int b = 0; b < nb; b++) begin
            chk("R6 ale at beat start", ale, 1'b1);
            chk("R4 beat active", beat_active, 1'b1);
            chk("R5 beat address", beat_addr, ea);
            chk("R5 beat direction", beat_write, wr);
            if (b == 0)  chk("R1 first beat size", beat_size, s);
            else if (bu) chk("R2 burst beat size", beat_size, s);
            else         chk("R3 later beat size", beat_size, pcode(pw));
            if (pw == 2'd0)      chk("R7 8-bit lanes", be_n, lanes(pw, s, ea[1:0]));
            else if (pw == 2'd1) chk("R8 16-bit lanes", be_n, lanes(pw, s, ea[1:0]));
            else                 chk("R9 32-bit lanes", be_n, lanes(pw, s, ea[1:0]));
            for (int w = 0; w < waits; w++) begin
                if (intrude && w == 0) begin
                    req_addr = ~a; req_valid = 1'b1;
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk("R6 ale low in wait", ale, 1'b0);
                chk("R11 address held", beat_addr, ea);
            end
            beat_done = 1'b1;
            @(negedge clk);
            beat_done = 1'b0;
            ea = ea + AW'(pbytes(pw));
        end
        chk("R12 done pulse", done, 1'b1);
        chk("R4 idle after last beat", beat_active, 1'b0);
        chk("R10 strobes idle", be_n, 4'b1111);
        @(negedge clk);
        chk("R12 done single cycle", done, 1'b0);
        chk("R11 no hidden transfer", beat_active, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R13 active after reset", beat_active, 1'b0);
        chk("R13 ale after reset", ale, 1'b0);
        chk("R13 done after reset", done, 1'b0);
        chk("R13 strobes after reset", be_n, 4'b1111);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_narrow_port();
        run_xfer(32'h0000_1000, 2'b00, 1'b1, 1'b0, 2'd0, 0, 1'b0); // R3 00,01,01,01
        run_xfer(32'h0000_2000, 2'b00, 1'b1, 1'b1, 2'd0, 1, 1'b0); // R2 00 on all
        run_xfer(32'h0000_2102, 2'b10, 1'b0, 1'b0, 2'd0, 3, 1'b1); // R11 stalled
    endtask

    task automatic t_half_port();
        run_xfer(32'h0000_3010, 2'b11, 1'b0, 1'b0, 2'd1, 0, 1'b0);
        run_xfer(32'h0000_3104, 2'b00, 1'b1, 1'b1, 2'd1, 2, 1'b0);
        run_xfer(32'h0000_3203, 2'b01, 1'b0, 1'b0, 2'd1, 0, 1'b0); // R8 odd byte
        run_xfer(32'h0000_3202, 2'b01, 1'b0, 1'b0, 2'd1, 0, 1'b0);
    endtask

    task automatic t_full_port();
        run_xfer(32'h0000_4020, 2'b11, 1'b0, 1'b1, 2'd2, 0, 1'b0);
        run_xfer(32'h0000_4040, 2'b11, 1'b1, 1'b0, 2'd3, 1, 1'b0);
        for (int k = 0; k < 4; k++)
            run_xfer(32'h0000_4100 + k, 2'b01, 1'b1, 1'b0, 2'd2, 0, 1'b0); // R9 bytes
        run_xfer(32'h0000_4202, 2'b10, 1'b0, 1'b0, 2'd2, 0, 1'b0);
        run_xfer(32'h0000_4200, 2'b10, 1'b0, 1'b0, 2'd2, 2, 1'b1);
        run_xfer(32'h0000_4300, 2'b00, 1'b1, 1'b0, 2'd2, 0, 1'b0);
    endtask

    task automatic t_stray_done();
        beat_done = 1'b1;
        @(negedge clk);
        beat_done = 1'b0;
        chk("R12 stray beat_done makes no done", done, 1'b0);
        chk("R10 stray beat_done keeps idle", be_n, 4'b1111);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_narrow_port();
        t_half_port();
        t_full_port();
        t_stray_done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule